// File: doc/BRIEF.md
# SPI Master Controller with Register Port

A single-select SPI master driven by software through a small word-addressed register port. Software sets the clock polarity, clock phase, word size and clock divider in a format register, drives the one chip-select line directly through a control bit, and starts a full-duplex exchange by writing a transmit word. The engine shifts the word out on MOSI, most significant bit first, and captures MISO into a receive register.

When the last clock edge of the word has passed, a completion flag rises and stays set until software writes the cause register. The exchange length is 8 or 16 bits. The SCK period is an even number N of system clocks, from 4 to 30, chosen by a prescale field.

Reads have one cycle of latency. All SPI outputs come straight from flops.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, the control register reads 0, the cause register reads 0, and the format register reads 0x0000001F (mode 0, 8-bit words, N = 30).
- R2: A write of bit 0 = 1 to the control register (offset 0x00) drives spi_cs_n to 0 on the next clock. A write of bit 0 = 0 drives it to 1. Bit 0 reads back the value written.
- R3: Register offsets are control 0x00, format 0x04, transmit 0x08, receive 0x0C and cause 0x10. The format register keeps only bits [4:0] (prescale), bit 5 (16-bit word), bit 11 (CPOL) and bit 12 (CPHA); all its other bits read 0. Unmapped offsets read 0.
- R4: A write to the transmit register while idle starts one exchange. The word goes out MSB first, the slave sees exactly one SCK edge pair per bit, and the MISO bits collected form the receive register value.
- R5: With format bit 5 clear, an exchange is 8 bits, only transmit bits [7:0] are sent, and receive bits [15:8] read 0. With bit 5 set, an exchange is 16 bits and uses bits [15:0].
- R6: When idle, spi_sck rests at the CPOL bit (format bit 11). With CPHA clear (bit 12), MISO is sampled on the leading SCK edge and MOSI changes on the trailing edge. With CPHA set, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R7: With prescale bit 4 set and H = prescale[3:0] of at least 2, every SCK half period lasts H system clocks, so SCK = clock / (2H).
- R8: A prescale value with bit 4 clear, or with [3:0] below 2, gives a half period of 2 clocks (N = 4).
- R9: The cause register reads 0 while an exchange runs and reads 1 once it has finished. A completion in the same cycle as a cause-register write leaves the flag set.
- R10: Any write to the cause register clears the completion flag.
- R11: A transmit write during an exchange is ignored. The running word completes unchanged, and the transmit register keeps reading the word that started the exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The assertions check several properties on every clock:
- the chip select follows the control write;
- a completion always leaves the cause flag set;
- the transmit register holds across writes made during an exchange;
- MOSI moves only together with an SCK edge;
- idle SCK sits at the programmed polarity.

Three things can only be shown by the bench's scenarios, which run a modelled slave in all four modes and at several dividers:
- the bit order and word length;
- which edge samples and which edge launches;
- the half-period length for valid and for out-of-range prescale codes.

// File: rtl/spi_hc_pkg.sv
package spi_hc_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 32;
  localparam int PRE_W    = 5;
  localparam int NARROW   = 8;
  localparam int WIDE     = 16;

  localparam logic [ADDR_W-1:0] OFF_CTL   = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_FMT   = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_TX    = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_RX    = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_CAUSE = 5'h10;

  localparam int FMT_WIDE_BIT = 5;
  localparam int FMT_CPOL_BIT = 11;
  localparam int FMT_CPHA_BIT = 12;

  localparam logic [PRE_W-1:0] PRE_RESET = 5'h1F;

  typedef struct packed {
    logic             cpha;
    logic             cpol;
    logic             wide;
    logic [PRE_W-1:0] pre;
  } fmt_t;
endpackage

// File: rtl/spi_hc_regs.sv
module spi_hc_regs
  import spi_hc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [WIDE-1:0]   rx_word,
  output logic              start,
  output logic [WIDE-1:0]   tx_word,
  output fmt_t              fmt,
  output logic              cs_n
);
  fmt_t            fmt_q;
  logic            cs_n_q;
  logic            flag_q;
  logic [WIDE-1:0] tx_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] fmt_word;
  logic            unused_wdata;

  assign unused_wdata = &{1'b0, bus_wdata[DATA_W-1:FMT_CPHA_BIT+1],
                          bus_wdata[FMT_CPOL_BIT-1:FMT_WIDE_BIT+1]};

  assign start   = bus_wr && (bus_addr == OFF_TX) && !busy;
  assign tx_word = bus_wdata[WIDE-1:0];
  assign fmt     = fmt_q;
  assign cs_n    = cs_n_q;

  always_comb begin
    fmt_word = '0;
    fmt_word[PRE_W-1:0]   = fmt_q.pre;
    fmt_word[FMT_WIDE_BIT] = fmt_q.wide;
    fmt_word[FMT_CPOL_BIT] = fmt_q.cpol;
    fmt_word[FMT_CPHA_BIT] = fmt_q.cpha;
  end

  always_comb begin
    case (bus_addr)
      OFF_CTL:   rd_mux = DATA_W'(!cs_n_q);
      OFF_FMT:   rd_mux = fmt_word;
      OFF_TX:    rd_mux = DATA_W'(tx_q);
      OFF_RX:    rd_mux = DATA_W'(rx_word);
      OFF_CAUSE: rd_mux = DATA_W'(flag_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_q    <= 1'b1;
      fmt_q     <= '{cpha: 1'b0, cpol: 1'b0, wide: 1'b0, pre: PRE_RESET};
      tx_q      <= '0;
      flag_q    <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          OFF_CTL: cs_n_q <= !bus_wdata[0];
          OFF_FMT: begin
            fmt_q.pre  <= bus_wdata[PRE_W-1:0];
            fmt_q.wide <= bus_wdata[FMT_WIDE_BIT];
            fmt_q.cpol <= bus_wdata[FMT_CPOL_BIT];
            fmt_q.cpha <= bus_wdata[FMT_CPHA_BIT];
          end
          OFF_TX:    if (!busy) tx_q <= bus_wdata[WIDE-1:0];
          OFF_CAUSE: flag_q <= 1'b0;
          default: ;
        endcase
      end
      if (done) flag_q <= 1'b1;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  // R2: select line follows the control write on the next clock
  a_r2_cs_follows_ctl: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_CTL) |=> (cs_n == !$past(bus_wdata[0])));

  // R9: a finished exchange always leaves the cause flag set
  a_r9_done_sets_flag: assert property (@(posedge clk) disable iff (rst)
    done |=> flag_q);

  // R11: transmit register untouched by writes during an exchange
  a_r11_tx_held_busy: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_TX && busy) |=> $stable(tx_q));
endmodule

// File: rtl/spi_hc_clkdiv.sv
module spi_hc_clkdiv
  import spi_hc_pkg::*;
#(
  parameter int PW = PRE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          run,
  input  logic [PW-1:0] pre,
  output logic          tick
);
  localparam int HW = PW - 1;
  localparam logic [HW-1:0] HALF_MIN = HW'(2);

  logic [HW-1:0] half_q;
  logic [HW-1:0] cnt_q;
  logic [HW-1:0] half_dec;
  logic          at_end;

  assign half_dec = (pre[PW-1] && pre[HW-1:0] >= HALF_MIN) ? pre[HW-1:0] : HALF_MIN;
  assign at_end   = (cnt_q == half_q - 1'b1);
  assign tick     = run && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= HALF_MIN;
      cnt_q  <= '0;
    end else begin
      if (start) half_q <= half_dec;
      if (!run || at_end) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_hc_shifter.sv
module spi_hc_shifter
  import spi_hc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [WIDE-1:0] tx_word,
  input  logic            wide,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            tick,
  input  logic            miso,
  output logic            busy,
  output logic            done,
  output logic [WIDE-1:0] rx_word,
  output logic            sck,
  output logic            mosi
);
  localparam int CNT_W = $clog2(2 * WIDE);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(2 * NARROW - 1);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(2 * WIDE - 1);

  logic             busy_q, done_q, sck_q;
  logic             m_wide, m_cpha;
  logic [CNT_W-1:0] ecnt_q;
  logic [WIDE-1:0]  tx_sh, rx_sh, rx_q, rx_nx;
  logic             lead, do_sample, do_shift, last_edge;

  assign lead      = !ecnt_q[0];
  assign do_sample = m_cpha ? !lead : lead;
  assign do_shift  = m_cpha ? (lead && ecnt_q != '0) : !lead;
  assign last_edge = (ecnt_q == (m_wide ? LAST_WIDE : LAST_NARROW));
  assign rx_nx     = do_sample ? {rx_sh[WIDE-2:0], miso} : rx_sh;

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_word = rx_q;
  assign sck     = sck_q;
  assign mosi    = tx_sh[WIDE-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sck_q  <= 1'b0;
      m_wide <= 1'b0;
      m_cpha <= 1'b0;
      ecnt_q <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        sck_q <= cpol;
        if (start) begin
          busy_q <= 1'b1;
          ecnt_q <= '0;
          m_wide <= wide;
          m_cpha <= cpha;
          rx_sh  <= '0;
          tx_sh  <= wide ? tx_word
                         : {tx_word[NARROW-1:0], {(WIDE-NARROW){1'b0}}};
        end
      end else if (tick) begin
        sck_q  <= !sck_q;
        ecnt_q <= ecnt_q + 1'b1;
        rx_sh  <= rx_nx;
        if (do_shift) tx_sh <= {tx_sh[WIDE-2:0], 1'b0};
        if (last_edge) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          rx_q   <= m_wide ? rx_nx
                           : {{(WIDE-NARROW){1'b0}}, rx_nx[NARROW-1:0]};
        end
      end
    end
  end

  // R4: outgoing data moves only together with a serial clock edge
  a_r4_mosi_on_edges: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q) && $stable(sck_q)) |-> $stable(tx_sh[WIDE-1]));

  // R6: idle serial clock rests at the programmed polarity
  a_r6_sck_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && $past(!busy_q)) |-> (sck_q == $past(cpol)));
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_hc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  fmt_t            fmt;
  logic            start, busy, done, tick;
  logic [WIDE-1:0] tx_word, rx_word;

  spi_hc_regs u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .rx_word(rx_word),
    .start(start), .tx_word(tx_word), .fmt(fmt), .cs_n(spi_cs_n)
  );

  spi_hc_clkdiv #(.PW(PRE_W)) u_div (
    .clk(clk), .rst(rst), .start(start), .run(busy),
    .pre(fmt.pre), .tick(tick)
  );

  spi_hc_shifter u_shift (
    .clk(clk), .rst(rst), .start(start), .tx_word(tx_word),
    .wide(fmt.wide), .cpol(fmt.cpol), .cpha(fmt.cpha),
    .tick(tick), .miso(spi_miso),
    .busy(busy), .done(done), .rx_word(rx_word),
    .sck(spi_sck), .mosi(spi_mosi)
  );
endmodule

// File: tb/spi_host_ctrl_tb.sv
module spi_host_ctrl_tb;
  localparam int CLK_P = 10;

  logic        clk = 0, rst = 1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_mosi, spi_cs_n;
  logic        spi_miso = 0;

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  // slave model state
  bit          armed = 0;
  bit          m_cpol = 0, m_cpha = 0;
  logic [15:0] slv_pat = '0, slv_rx = '0;
  int          slv_idx = 0, edges = 0;
  time         last_edge_t = 0, last_gap = 0;

  always #(CLK_P/2) clk = !clk;

  spi_host_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  always @(spi_sck) begin
    if (armed && spi_cs_n == 1'b0) begin
      bit lead;
      lead = (spi_sck != m_cpol);
      edges++;
      if (edges >= 2) last_gap = $time - last_edge_t;
      last_edge_t = $time;
      if (lead == !m_cpha) begin
        slv_rx = {slv_rx[14:0], spi_mosi};
      end else if (slv_idx >= 0) begin
        spi_miso = slv_pat[slv_idx];
        slv_idx--;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      failures++;
      $display("FAIL watchdog: got cycle %0d exp below 150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int exp_half(input logic [4:0] pre);
    return (pre[4] && pre[3:0] >= 2) ? int'(pre[3:0]) : 2;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 1000; i++) begin
      reg_rd(5'h10, v);
      if (v[0]) begin ok = 1; break; end
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 cs_n", 32'(spi_cs_n), 32'd1);
    check("R1 sck", 32'(spi_sck), 32'd0);
    reg_rd(5'h00, v); check("R1 ctl", v, 32'h0);
    reg_rd(5'h04, v); check("R1 fmt", v, 32'h1F);
    reg_rd(5'h10, v); check("R1 cause", v, 32'h0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    reg_wr(5'h04, 32'hFFFF_FFFF);
    reg_rd(5'h04, v); check("R3 fmt fields", v, 32'h0000_183F);
    @(negedge clk);
    check("R6 idle sck cpol=1", 32'(spi_sck), 32'd1);
    reg_rd(5'h14, v); check("R3 unmapped", v, 32'h0);
    reg_wr(5'h04, 32'h0000_001F);
    @(negedge clk);
    check("R6 idle sck cpol=0", 32'(spi_sck), 32'd0);
  endtask

  task automatic t_cs;
    logic [31:0] v;
    reg_wr(5'h00, 32'h1);
    check("R2 cs asserted", 32'(spi_cs_n), 32'd0);
    reg_rd(5'h00, v); check("R2 ctl readback", v, 32'h1);
    reg_wr(5'h00, 32'h0);
    check("R2 cs released", 32'(spi_cs_n), 32'd1);
  endtask

  // one full exchange, slave replies with pat
  task automatic xfer(input bit cpol, input bit cpha, input bit wide,
                      input logic [4:0] pre, input logic [15:0] txw,
                      input logic [15:0] pat, input string tag);
    logic [31:0] v;
    bit ok;
    int nb;
    nb = wide ? 16 : 8;
    reg_wr(5'h04, {19'b0, cpha, cpol, 5'b0, wide, pre});
    @(negedge clk);
    check({tag, " R6 idle level"}, 32'(spi_sck), 32'(cpol));
    m_cpol = cpol; m_cpha = cpha;
    slv_pat = pat; slv_rx = '0; edges = 0; last_gap = 0;
    if (!cpha) begin spi_miso = pat[nb-1]; slv_idx = nb - 2; end
    else       slv_idx = nb - 1;
    armed = 1;
    reg_wr(5'h00, 32'h1);
    reg_wr(5'h10, 32'h0);
    reg_wr(5'h08, {16'hDEAD, txw});
    reg_rd(5'h10, v); check({tag, " R9 flag low while busy"}, v, 32'h0);
    wait_done(ok);
    check({tag, " R9 completion seen"}, 32'(ok), 32'd1);
    check({tag, " R4 edge count"}, 32'(edges), 32'(2 * nb));
    check({tag, " R7 half period"}, 32'(last_gap), 32'(exp_half(pre) * CLK_P));
    check({tag, " R4 R5 slave got"}, 32'(slv_rx),
          wide ? 32'(txw) : 32'(txw[7:0]));
    reg_rd(5'h0C, v);
    check({tag, " R4 R5 rx word"}, v, wide ? 32'(pat) : 32'(pat[7:0]));
    reg_wr(5'h10, 32'h0);
    reg_rd(5'h10, v); check({tag, " R10 flag cleared"}, v, 32'h0);
    reg_wr(5'h00, 32'h0);
    armed = 0;
  endtask

  task automatic t_busy_write;
    logic [31:0] v;
    bit ok;
    reg_wr(5'h04, 32'h0000_0013);
    m_cpol = 0; m_cpha = 0;
    slv_pat = 16'h005A; slv_rx = '0; edges = 0;
    spi_miso = 1'b0; slv_idx = 6;
    armed = 1;
    reg_wr(5'h00, 32'h1);
    reg_wr(5'h08, 32'h0000_00A5);
    repeat (6) @(negedge clk);
    reg_wr(5'h08, 32'h0000_003C);
    wait_done(ok);
    check("R11 exchange done", 32'(ok), 32'd1);
    check("R11 slave saw first word", 32'(slv_rx), 32'h00A5);
    check("R11 edges of one word", 32'(edges), 32'd16);
    reg_rd(5'h08, v); check("R11 tx readback", v, 32'h00A5);
    reg_rd(5'h0C, v); check("R11 rx word", v, 32'h005A);
    reg_wr(5'h10, 32'h0);
    reg_wr(5'h00, 32'h0);
    armed = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_cs();
    xfer(0, 0, 0, 5'h1F, 16'h00C3, 16'h0096, "mode0 n30");
    xfer(0, 1, 1, 5'h13, 16'hB1E7, 16'h4D2A, "mode1 n6");
    xfer(1, 0, 0, 5'h12, 16'h1234, 16'h0081, "mode2 n4");
    xfer(1, 1, 1, 5'h1F, 16'h8001, 16'hF00F, "mode3 n30");
    xfer(0, 0, 1, 5'h05, 16'h6C39, 16'h9AC5, "R8 bit4 clear");
    xfer(1, 0, 0, 5'h11, 16'h0077, 16'h00E8, "R8 half below 2");
    t_busy_write();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule